// File: doc/BRIEF.md
# Extended Instruction Address Generator

This block sits behind an instruction byte stream of a small 24-bit teaching processor. It collects the bytes of a three-byte or four-byte instruction one per clock and splits them into the opcode and the six addressing flags. It then forms the 20-bit target address from the program counter, the base register or the raw field, with the index register added when requested. It also classifies the operand as immediate, indirect or simple. The fourth flag decides on the second byte whether a fourth byte follows.

Bytes arrive over a valid/ready handshake. A byte is taken on a rising edge where `in_valid` and `in_ready` are both high. The source must hold `in_byte` steady while `in_valid` is high and `in_ready` is low. The block applies back-pressure only in the single cycle in which it presents a result, so one instruction can follow another with a one-cycle gap. The result fields stay on their registers until the next result. A pulse on `done` marks a legal instruction. A pulse on `error` marks the forbidden combination of both relative flags.

Top module: `xaddr_gen`

## Requirements
- R1: A byte is accepted only on a clock edge where in_valid and in_ready are both high. Byte 0 holds the opcode in bits 7:2, n in bit 1 and i in bit 0. Byte 1 holds x, b, p, e in bits 7 down to 4 and the top four field bits in bits 3:0. The following bytes carry the rest of the field, most significant first.
- R2: With e=0 the instruction is three bytes long and carries a 12-bit displacement. With e=1 it is four bytes long and carries a 20-bit address. The result strobe rises in the cycle after the last byte is accepted and lasts one cycle. The `flags` output is {n,i,x,b,p,e} with n in bit 5.
- R3: With b=0 and p=1 the target is the next-instruction address (first-byte address plus 3, or plus 4 when e=1) plus the field. In the three-byte form the 12-bit field is sign-extended.
- R4: With b=1 and p=0 the target is the base register plus the field, which is taken as unsigned.
- R5: With b=0 and p=0 the field itself is the target.
- R6: With x=1 the index register is added to the target in the base-relative, PC-relative and direct forms alike.
- R7: `mode` is 0 (simple) when n equals i, 1 (immediate) for n=0 and i=1, and 2 (indirect) for n=1 and i=0.
- R8: With b=1 and p=1, `error` pulses in place of `done`. The two strobes are never high together.
- R9: The target wraps modulo 2^20. Register bits above bit 19 do not affect it.
- R10: in_ready is low exactly in the cycles where done or error is high. A byte offered there is not taken, and the next instruction's first byte is taken in the following cycle.
- R11: After reset done and error are low, in_ready is high, and opcode, flags, mode and target are zero.
- R12: start_pc is sampled with the first byte. base_reg and index_reg are sampled with the last byte. Their values at any other time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction byte present |
| in_ready | output | 1 | Block can take a byte |
| in_byte | input | 8 | Instruction byte |
| start_pc | input | ADDR_W | Address of the instruction's first byte |
| base_reg | input | REG_W | Base register value |
| index_reg | input | REG_W | Index register value |
| done | output | 1 | Legal instruction result strobe |
| error | output | 1 | Illegal relative-flag combination strobe |
| opcode | output | 6 | Opcode of the last instruction |
| flags | output | 6 | {n,i,x,b,p,e} of the last instruction |
| mode | output | 2 | Operand mode: 0 simple, 1 immediate, 2 indirect |
| target | output | ADDR_W | Computed target address |

## Verification
A byte counter that has drifted shows up as a strobe after the wrong number of accepted bytes. It also shows up as an instruction whose fields are shifted by a byte, visible on the very next result. A stale program-counter or register capture shows up as a wrong target on the same result, so the bench changes those inputs outside their sampling cycle. A stuck result register shows up as a second strobe or as in_ready staying low, which is checked one cycle after every result.

// File: rtl/xag_pkg.sv
package xag_pkg;
  localparam int BYTE_W  = 8;
  localparam int OP_W    = 6;
  localparam int FIELD_W = 20;
  localparam int DISP_W  = 12;

  typedef enum logic [1:0] {
    MODE_SIMPLE = 2'd0,
    MODE_IMM    = 2'd1,
    MODE_IND    = 2'd2
  } opnd_mode_e;

  typedef struct packed {
    logic n;
    logic i;
    logic x;
    logic b;
    logic p;
    logic e;
  } addr_flags_t;
endpackage

// File: rtl/xag_collect.sv
module xag_collect
  import xag_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  logic [BYTE_W-1:0]   byte_in,
  input  logic [ADDR_W-1:0]   pc_in,
  output logic                last,
  output logic [OP_W-1:0]     op,
  output addr_flags_t         fl,
  output logic [FIELD_W-1:0]  field,
  output logic [ADDR_W-1:0]   pc_first
);
  logic [1:0]        cnt;
  logic [BYTE_W-1:0] b0, b1, b2;

  // the long form is known from byte 1, stored before byte 2 arrives
  assign last = acc && ((cnt == 2'd2 && !b1[4]) || cnt == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      b0       <= '0;
      b1       <= '0;
      b2       <= '0;
      pc_first <= '0;
    end else if (acc) begin
      case (cnt)
        2'd0: begin
          b0       <= byte_in;
          pc_first <= pc_in;
          cnt      <= 2'd1;
        end
        2'd1: begin
          b1  <= byte_in;
          cnt <= 2'd2;
        end
        2'd2: begin
          if (b1[4]) begin
            b2  <= byte_in;
            cnt <= 2'd3;
          end else begin
            cnt <= 2'd0;
          end
        end
        default: cnt <= 2'd0;
      endcase
    end
  end

  always_comb begin
    op   = b0[7:2];
    fl.n = b0[1];
    fl.i = b0[0];
    fl.x = b1[7];
    fl.b = b1[6];
    fl.p = b1[5];
    fl.e = b1[4];
    if (b1[4]) field = {b1[3:0], b2, byte_in};
    else       field = {8'd0, b1[3:0], byte_in};
  end
endmodule

// File: rtl/xag_tgt.sv
module xag_tgt
  import xag_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int REG_W  = 24
) (
  input  addr_flags_t         fl,
  input  logic [FIELD_W-1:0]  field,
  input  logic [ADDR_W-1:0]   pc_first,
  input  logic [REG_W-1:0]    base_val,
  input  logic [REG_W-1:0]    index_val,
  output logic [ADDR_W-1:0]   tgt,
  output logic                illegal,
  output opnd_mode_e          md
);
  localparam int EXT_W = FIELD_W - DISP_W;

  logic [ADDR_W-1:0]         pc_next;
  logic signed [FIELD_W-1:0] rel_field;
  logic [REG_W-1:0]          off, base_term, idx_term, sum;

  always_comb begin
    pc_next   = pc_first + (fl.e ? ADDR_W'(4) : ADDR_W'(3));
    rel_field = fl.e ? field : {{EXT_W{field[DISP_W-1]}}, field[DISP_W-1:0]};
    illegal   = fl.b && fl.p;

    if (!fl.b && fl.p) begin
      off       = REG_W'(rel_field);
      base_term = REG_W'(pc_next);
    end else if (fl.b && !fl.p) begin
      off       = REG_W'(field);
      base_term = base_val;
    end else begin
      off       = REG_W'(field);
      base_term = '0;
    end

    idx_term = fl.x ? index_val : '0;
    sum      = base_term + off + idx_term;
    tgt      = sum[ADDR_W-1:0];

    if (fl.n == fl.i) md = MODE_SIMPLE;
    else if (fl.n)    md = MODE_IND;
    else              md = MODE_IMM;
  end
endmodule

// File: rtl/xaddr_gen.sv
module xaddr_gen
  import xag_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int REG_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic [REG_W-1:0]  base_reg,
  input  logic [REG_W-1:0]  index_reg,
  output logic              done,
  output logic              error,
  output logic [5:0]        opcode,
  output logic [5:0]        flags,
  output logic [1:0]        mode,
  output logic [ADDR_W-1:0] target
);
  logic               acc, last, illegal;
  logic [OP_W-1:0]    op_c;
  addr_flags_t        fl_c;
  logic [FIELD_W-1:0] field_c;
  logic [ADDR_W-1:0]  pc_first, tgt_c;
  opnd_mode_e         md_c;

  assign in_ready = !(done || error);
  assign acc      = in_valid && in_ready;

  xag_collect #(.ADDR_W(ADDR_W)) u_collect (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc      (acc),
    .byte_in  (in_byte),
    .pc_in    (start_pc),
    .last     (last),
    .op       (op_c),
    .fl       (fl_c),
    .field    (field_c),
    .pc_first (pc_first)
  );

  xag_tgt #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_tgt (
    .fl        (fl_c),
    .field     (field_c),
    .pc_first  (pc_first),
    .base_val  (base_reg),
    .index_val (index_reg),
    .tgt       (tgt_c),
    .illegal   (illegal),
    .md        (md_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      error  <= 1'b0;
      opcode <= '0;
      flags  <= '0;
      mode   <= '0;
      target <= '0;
    end else begin
      done  <= last && !illegal;
      error <= last && illegal;
      if (last) begin
        opcode <= op_c;
        flags  <= fl_c;
        mode   <= md_c;
        target <= tgt_c;
      end
    end
  end
endmodule

// File: rtl/xag_chk.sv
module xag_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       done,
  input logic       error,
  input logic [5:0] flags,
  input logic [1:0] mode
);
  logic [2:0] nbytes;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  nbytes <= '0;
    else if (done || error)      nbytes <= '0;
    else if (in_valid && in_ready) nbytes <= nbytes + 3'd1;
  end

  // R10
  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> !in_ready);
  // R8
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  a_r8_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (flags[2] && flags[1]));
  a_r8_legal: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(flags[2] && flags[1]));
  // R7
  a_r7_mode: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mode == ((flags[5] == flags[4]) ? 2'd0 : (flags[5] ? 2'd2 : 2'd1))));
  // R2
  a_r2_length: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (nbytes == (flags[0] ? 3'd4 : 3'd3)));
  a_r2_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind xaddr_gen xag_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .done     (done),
  .error    (error),
  .flags    (flags),
  .mode     (mode)
);

// File: tb/test_xaddr_gen.sv
`timescale 1ns/1ps
module test_xaddr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = '0;
  logic [19:0] start_pc = '0;
  logic [23:0] base_reg = '0;
  logic [23:0] index_reg = '0;
  logic        done, error;
  logic [5:0]  opcode, flags;
  logic [1:0]  mode;
  logic [19:0] target;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    bit          err;
    logic [5:0]  op;
    logic [5:0]  fl;
    logic [19:0] tg;
    logic [1:0]  md;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  xaddr_gen i_xaddr_gen (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_byte(in_byte), .start_pc(start_pc), .base_reg(base_reg),
    .index_reg(index_reg), .done(done), .error(error), .opcode(opcode),
    .flags(flags), .mode(mode), .target(target)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_target(logic [5:0] fl, logic [19:0] fld,
      logic [19:0] pc, logic [23:0] base, logic [23:0] idx);
    int unsigned nb, d, t;
    nb = fl[0] ? 4 : 3;
    if (fl[0]) d = fld;
    else if (fl[1] && !fl[2]) d = fld[11] ? (32'hFFFFF000 | fld[11:0]) : fld[11:0];
    else d = fld[11:0];
    if (fl[2] && !fl[1])      t = base + d;
    else if (!fl[2] && fl[1]) t = pc + nb + d;
    else                      t = d;
    if (fl[3]) t = t + idx;
    return t[19:0];
  endfunction

  function automatic logic [1:0] exp_mode(logic n, logic i);
    if (n == i) return 2'd0;
    return n ? 2'd2 : 2'd1;
  endfunction

  // driver: fl = {n,i,x,b,p,e}
  task automatic send(string req, logic [5:0] op, logic [5:0] fl, logic [19:0] fld,
      logic [19:0] pc, logic [23:0] base, logic [23:0] idx, bit gaps);
    exp_t e;
    logic [7:0] bytes[4];
    int nb;
    nb = fl[0] ? 4 : 3;
    bytes[0] = {op, fl[5], fl[4]};
    bytes[1] = {fl[3], fl[2], fl[1], fl[0], fl[0] ? fld[19:16] : fld[11:8]};
    if (fl[0]) begin
      bytes[2] = fld[15:8];
      bytes[3] = fld[7:0];
    end else begin
      bytes[2] = fld[7:0];
      bytes[3] = 8'h00;
    end
    e.err = fl[2] && fl[1];
    e.op  = op;
    e.fl  = fl;
    e.tg  = exp_target(fl, fld, pc, base, idx);
    e.md  = exp_mode(fl[5], fl[4]);
    e.req = req;
    sb.push_back(e);
    for (int k = 0; k < nb; k++) begin
      bit rdy;
      @(negedge clk);
      if (gaps && k > 0) begin
        in_valid = 1'b0;
        in_byte  = 8'hA5;
        start_pc = ~pc;
        @(negedge clk);
      end
      in_valid  = 1'b1;
      in_byte   = bytes[k];
      start_pc  = (k == 0) ? pc : ~pc;            // R12
      base_reg  = (k == nb - 1) ? base : ~base;
      index_reg = (k == nb - 1) ? idx : ~idx;
      do begin
        rdy = in_ready;
        @(posedge clk);
        if (!rdy) @(negedge clk);
      end while (!rdy);
    end
    @(negedge clk);
    in_valid  = 1'b0;
    start_pc  = 20'h5A5A5;
    base_reg  = 24'h123456;
    index_reg = 24'h654321;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && (done || error)) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected result", {31'd0, done}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(error == e.err && done == !e.err, {e.req, " R8 strobe"},
              {30'd0, error, done}, {30'd0, e.err, !e.err});
        check(opcode == e.op && flags == e.fl, {e.req, " R1 fields"},
              {20'd0, opcode, flags}, {20'd0, e.op, e.fl});
        if (!e.err) begin
          check(target == e.tg, {e.req, " target"}, {12'd0, target}, {12'd0, e.tg});
          check(mode == e.md, {e.req, " R7 mode"}, {30'd0, mode}, {30'd0, e.md});
        end
        check(in_ready == 1'b0, "R10 ready low with result", {31'd0, in_ready}, 32'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done && !error && in_ready, "R11 strobes and ready",
          {29'd0, done, error, in_ready}, 32'd1);
    check(opcode == 0 && flags == 0 && mode == 0 && target == 0, "R11 outputs zero",
          {opcode, flags, mode, target}, 32'd0);

    // {n,i,x,b,p,e}
    send("R3 pc-rel positive",   6'h05, 6'b110010, 20'h00123, 20'h01000, 24'h0, 24'h0, 0);
    send("R3 pc-rel negative",   6'h06, 6'b110010, 20'h00FF0, 20'h02000, 24'h0, 24'h0, 1);
    send("R4 base unsigned",     6'h07, 6'b110100, 20'h00FFF, 20'h03000, 24'h004000, 24'h0, 0);
    send("R5 direct short",      6'h08, 6'b110000, 20'h00ABC, 20'h04000, 24'h0, 24'h0, 0);
    send("R6 R5 long direct x",  6'h09, 6'b111001, 20'hF1234, 20'h05000, 24'h0, 24'h000010, 0);
    send("R3 long pc-rel",       6'h0A, 6'b100011, 20'h10000, 20'h06000, 24'h0, 24'h0, 1);
    send("R6 base indexed",      6'h0B, 6'b111100, 20'h00010, 20'h07000, 24'h001000, 24'h000100, 0);
    send("R6 pc-rel imm x",      6'h0C, 6'b011010, 20'h00800, 20'h08000, 24'h0, 24'h000050, 0);
    send("R8 illegal b and p",   6'h0D, 6'b110110, 20'h00001, 20'h09000, 24'h0, 24'h0, 0);
    send("R9 base wrap",         6'h0E, 6'b110100, 20'h00020, 20'h0A000, 24'hFFFFF0, 24'h0, 0);
    send("R7 indirect long gap", 6'h0F, 6'b100001, 20'h54321, 20'h0B000, 24'h0, 24'h0, 1);
    send("R10 after error",      6'h10, 6'b000000, 20'h00777, 20'h0C000, 24'h0, 24'h0, 0);
    send("R9 pc-rel top wrap",   6'h11, 6'b110010, 20'h00100, 20'hFFFFE, 24'h0, 24'h0, 0);
    send("R9 index upper bits",  6'h12, 6'b111000, 20'h00005, 20'h0D000, 24'h0, 24'hF00003, 0);

    repeat (6) @(negedge clk);
    check(sb.size() == 0, "R2 all results seen", sb.size(), 32'd0);
    check(!done && !error && in_ready, "R10 idle after results",
          {29'd0, done, error, in_ready}, 32'd1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule